// File: doc/BRIEF.md
# Page Access Permission and Fault Code Unit

This combinational unit decides whether a memory access may use a translation that has already been fully walked. It takes the rights accumulated over the walk (user, writable, no-execute), the protection key stored in the leaf entry, and the kind of access: read, write or instruction fetch. From these it forms a read/write/execute permission mask and an allow flag. When the access is refused, it also forms the page-fault error code that the exception logic reports.

On top of the plain user and writable checks, the unit handles four further controls. The supervisor write-protect control decides whether a supervisor write may go to a read-only page. A supervisor-execute guard stops supervisor code from fetching out of user pages. Protection keys are taken from one rights register for user pages and from another for supervisor pages. Not-present and reserved-bit conditions come in from the walker and shape the error code. The unit has no state, so the result follows the inputs in the same cycle.

Top module: `pf_access_check`

## Requirements
- R1: A user-mode access to a page whose user bit is clear gets a zero permission mask and is refused. Its error code has bit 0 set and bit 5 clear.
- R2: Write permission (mask bit 1) is granted when the page is writable. It is also granted when the access is supervisor and the write-protect control is clear. Protection keys can still remove it (R6).
- R3: Execute permission (mask bit 2) requires the no-execute bit to be clear. It is also denied for a supervisor access to a user page while the supervisor-execute guard is enabled.
- R4: Read permission (mask bit 0) is granted unless R1 applies or a key access-disable bit removes it.
- R5: Protection keys apply only in long mode. User pages take their rights from the user rights register when its enable is set. Supervisor pages take theirs from the supervisor rights register when that enable is set. In every other case the rights value is zero.
- R6: For key k, rights bit 2k removes read and write. Rights bit 2k+1 removes write only when the access is user mode or the write-protect control is set. Keys never affect execute.
- R7: When the key rights deny the requested read or write, error code bit 5 is set. This holds only when R1 does not apply and the walker reports no fault.
- R8: Access type encodings are 0 read, 1 write, 2 fetch, and 3 reserved. The access is allowed when the mask bit of the same index is set and the walker reports neither fault. Type 3 is never allowed. An allowed access gives an all-zero error code.
- R9: On a refused access, the error code bits are set as follows. Bit 0 is set unless the page is not present. Bit 1 is set for writes. Bit 2 is set for user mode. Bit 3 is set for a reserved-bit fault. All bits above bit 5 are zero.
- R10: Error code bit 4 is set on a refused fetch only when both the no-execute enable and the extended-address enable are set, or when the supervisor-execute guard is set.
- R11: A not-present fault takes priority. It clears bits 0, 3 and 5, and the access is refused. A reserved-bit fault comes next. It sets bits 0 and 3, clears bit 5, and the access is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_type_i | input | 2 | Access type: 0 read, 1 write, 2 fetch, 3 reserved |
| user_mode_i | input | 1 | Access is made at user privilege |
| pg_user_i | input | 1 | Combined user bit of the walk |
| pg_rw_i | input | 1 | Combined writable bit of the walk |
| pg_nx_i | input | 1 | Combined no-execute bit of the walk |
| pkey_i | input | KEY_W | Protection key of the leaf entry |
| wp_i | input | 1 | Supervisor write-protect control |
| smep_i | input | 1 | Supervisor-execute guard enable |
| nxe_i | input | 1 | No-execute enable |
| pae_i | input | 1 | Extended physical address mode |
| pke_i | input | 1 | User-page protection key enable |
| pks_i | input | 1 | Supervisor-page protection key enable |
| lma_i | input | 1 | Long mode active |
| urights_i | input | 2*2**KEY_W | User-page key rights register |
| srights_i | input | 2*2**KEY_W | Supervisor-page key rights register |
| not_present_i | input | 1 | Walker found a not-present entry |
| rsvd_i | input | 1 | Walker found a reserved bit set |
| perm_o | output | 3 | Permission mask: bit 0 read, 1 write, 2 execute |
| allow_o | output | 1 | Access is allowed |
| err_o | output | ERR_W | Page-fault error code, zero when allowed |

## Verification
The bench builds the unit with its defaults: 4-bit keys, and therefore 32-bit rights registers and a 16-bit error code. With these, all sixteen key slots in both rights registers can be reached, and the error code bits above bit 5 can be checked for zero. Directed cases cover each fault kind and the priorities between them. These include a key denial hidden behind a reserved-bit fault and a write-disable bit that is ignored for a supervisor write while write-protect is clear. Random vectors over every input are also compared against a behavioural model on every clock.

// File: rtl/pf_pkg.sv
package pf_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSV   = 2'd3
  } acc_e;

  localparam int unsigned PERM_R = 0;
  localparam int unsigned PERM_W = 1;
  localparam int unsigned PERM_X = 2;

  localparam int unsigned EC_P    = 0;
  localparam int unsigned EC_W    = 1;
  localparam int unsigned EC_U    = 2;
  localparam int unsigned EC_RSVD = 3;
  localparam int unsigned EC_ID   = 4;
  localparam int unsigned EC_PK   = 5;
  localparam int unsigned EC_USED = 6;
endpackage

// File: rtl/pf_base_perm.sv
module pf_base_perm
  import pf_pkg::*;
(
  input  logic       user_mode_i,
  input  logic       pg_user_i,
  input  logic       pg_rw_i,
  input  logic       pg_nx_i,
  input  logic       wp_i,
  input  logic       smep_i,
  output logic       user_viol_o,
  output logic [2:0] perm_o
);
  logic rd_ok, wr_ok, ex_ok;

  always_comb begin
    user_viol_o = user_mode_i && !pg_user_i;
    rd_ok = 1'b1;
    wr_ok = pg_rw_i || (!user_mode_i && !wp_i);
    ex_ok = !pg_nx_i && (user_mode_i || !(smep_i && pg_user_i));
    perm_o = '0;
    if (!user_viol_o) begin
      perm_o[PERM_R] = rd_ok;
      perm_o[PERM_W] = wr_ok;
      perm_o[PERM_X] = ex_ok;
    end
  end

  always_comb begin
    // R1: a user access to a supervisor page gets no rights
    p_user_page_r1: assert (!(user_mode_i && !pg_user_i) || perm_o == 3'b000);
    // R3: no-execute always blocks execute
    p_nx_blocks_r3: assert (!pg_nx_i || !perm_o[PERM_X]);
  end
endmodule

// File: rtl/pf_key_rights.sv
module pf_key_rights #(
  parameter int unsigned KEY_W    = 4,
  localparam int unsigned KEYS    = 1 << KEY_W,
  localparam int unsigned RIGHTS_W = 2 * KEYS
) (
  input  logic [KEY_W-1:0]    pkey_i,
  input  logic                pg_user_i,
  input  logic                user_mode_i,
  input  logic                wp_i,
  input  logic                pke_i,
  input  logic                pks_i,
  input  logic                lma_i,
  input  logic [RIGHTS_W-1:0] urights_i,
  input  logic [RIGHTS_W-1:0] srights_i,
  output logic [1:0]          key_rw_o   // bit 0 read kept, bit 1 write kept
);
  logic [RIGHTS_W-1:0] rights;
  logic [KEYS-1:0]     ad_vec, wd_vec;
  logic                ad, wd;

  always_comb begin
    rights = '0;
    if (lma_i) begin
      if (pg_user_i) rights = pke_i ? urights_i : '0;
      else           rights = pks_i ? srights_i : '0;
    end
  end

  for (genvar g = 0; g < KEYS; g++) begin : g_key
    assign ad_vec[g] = rights[2*g];
    assign wd_vec[g] = rights[2*g+1];
  end

  always_comb begin
    ad = ad_vec[pkey_i];
    wd = wd_vec[pkey_i];
    key_rw_o = 2'b11;
    if (ad)
      key_rw_o = 2'b00;
    else if (wd && (user_mode_i || wp_i))
      key_rw_o = 2'b01;
  end

  always_comb begin
    // R5: keys are inert outside long mode
    p_no_keys_legacy_r5: assert (lma_i || key_rw_o == 2'b11);
    // R6: write-disable alone never takes read away
    p_read_kept_r6: assert (key_rw_o[0] || !key_rw_o[1]);
  end
endmodule

// File: rtl/pf_err_code.sv
module pf_err_code
  import pf_pkg::*;
#(
  parameter int unsigned ERR_W = 16
) (
  input  logic [1:0]       acc_type_i,
  input  logic             user_mode_i,
  input  logic             not_present_i,
  input  logic             rsvd_i,
  input  logic             pk_fault_i,
  input  logic             nxe_i,
  input  logic             pae_i,
  input  logic             smep_i,
  input  logic             allow_i,
  output logic [ERR_W-1:0] err_o
);
  acc_e acc;

  always_comb begin
    acc   = acc_e'(acc_type_i);
    err_o = '0;
    if (!allow_i) begin
      err_o[EC_P]    = !not_present_i;
      err_o[EC_W]    = (acc == ACC_WRITE);
      err_o[EC_U]    = user_mode_i;
      err_o[EC_RSVD] = !not_present_i && rsvd_i;
      err_o[EC_ID]   = (acc == ACC_FETCH) && ((nxe_i && pae_i) || smep_i);
      err_o[EC_PK]   = !not_present_i && !rsvd_i && pk_fault_i;
    end
  end

  always_comb begin
    // R11: not-present wins over every other fault kind
    p_np_priority_r11: assert (!not_present_i || allow_i ||
                               (!err_o[EC_P] && !err_o[EC_RSVD] && !err_o[EC_PK]));
    // R10: fetch bit only on fetches
    p_fetch_bit_r10: assert (!err_o[EC_ID] || acc_type_i == 2'd2);
  end
endmodule

// File: rtl/pf_access_check.sv
module pf_access_check
  import pf_pkg::*;
#(
  parameter int unsigned KEY_W    = 4,
  parameter int unsigned ERR_W    = 16,
  localparam int unsigned RIGHTS_W = 2 * (1 << KEY_W)
) (
  input  logic [1:0]          acc_type_i,
  input  logic                user_mode_i,
  input  logic                pg_user_i,
  input  logic                pg_rw_i,
  input  logic                pg_nx_i,
  input  logic [KEY_W-1:0]    pkey_i,
  input  logic                wp_i,
  input  logic                smep_i,
  input  logic                nxe_i,
  input  logic                pae_i,
  input  logic                pke_i,
  input  logic                pks_i,
  input  logic                lma_i,
  input  logic [RIGHTS_W-1:0] urights_i,
  input  logic [RIGHTS_W-1:0] srights_i,
  input  logic                not_present_i,
  input  logic                rsvd_i,
  output logic [2:0]          perm_o,
  output logic                allow_o,
  output logic [ERR_W-1:0]    err_o
);
  logic [2:0] base_perm;
  logic       user_viol;
  logic [1:0] key_rw;
  logic       pk_fault;
  logic       acc_ok;

  pf_base_perm u_base (
    .user_mode_i (user_mode_i),
    .pg_user_i   (pg_user_i),
    .pg_rw_i     (pg_rw_i),
    .pg_nx_i     (pg_nx_i),
    .wp_i        (wp_i),
    .smep_i      (smep_i),
    .user_viol_o (user_viol),
    .perm_o      (base_perm)
  );

  pf_key_rights #(.KEY_W(KEY_W)) u_keys (
    .pkey_i      (pkey_i),
    .pg_user_i   (pg_user_i),
    .user_mode_i (user_mode_i),
    .wp_i        (wp_i),
    .pke_i       (pke_i),
    .pks_i       (pks_i),
    .lma_i       (lma_i),
    .urights_i   (urights_i),
    .srights_i   (srights_i),
    .key_rw_o    (key_rw)
  );

  always_comb begin
    perm_o = {base_perm[PERM_X],
              base_perm[PERM_W] & key_rw[1],
              base_perm[PERM_R] & key_rw[0]};
    pk_fault = 1'b0;
    acc_ok   = 1'b0;
    unique case (acc_type_i)
      2'd0: begin acc_ok = perm_o[PERM_R]; pk_fault = !user_viol && !key_rw[0]; end
      2'd1: begin acc_ok = perm_o[PERM_W]; pk_fault = !user_viol && !key_rw[1]; end
      2'd2: acc_ok = perm_o[PERM_X];
      default: acc_ok = 1'b0;
    endcase
    allow_o = acc_ok && !not_present_i && !rsvd_i;
  end

  pf_err_code #(.ERR_W(ERR_W)) u_err (
    .acc_type_i    (acc_type_i),
    .user_mode_i   (user_mode_i),
    .not_present_i (not_present_i),
    .rsvd_i        (rsvd_i),
    .pk_fault_i    (pk_fault),
    .nxe_i         (nxe_i),
    .pae_i         (pae_i),
    .smep_i        (smep_i),
    .allow_i       (allow_o),
    .err_o         (err_o)
  );

  always_comb begin
    // R8: an allowed access carries no error code
    p_allow_clean_r8: assert (!allow_o || err_o == '0);
    // R8: reserved access type is refused
    p_rsv_type_r8: assert (acc_type_i != 2'd3 || !allow_o);
    // R7: key bit only when requested right is missing from the mask
    p_pk_denied_r7: assert (!err_o[EC_PK] || (acc_type_i < 2'd2 && !perm_o[acc_type_i]));
    // R9: high error bits stay clear
    p_err_high_r9: assert ((err_o >> EC_USED) == '0);
  end
endmodule

// File: tb/pf_access_check_test.sv
module pf_access_check_test;
  localparam int KEY_W = 4;
  localparam int ERR_W = 16;
  localparam int RW    = 2 * (1 << KEY_W);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [1:0]       acc;
  logic             um, pu, prw, pnx, wp, smep, nxe, pae, pke, pks, lma, np, rsvd;
  logic [KEY_W-1:0] pkey;
  logic [RW-1:0]    ur, sr;
  logic [2:0]       perm;
  logic             allow;
  logic [ERR_W-1:0] err;

  int checks = 0;
  int errors = 0;

  pf_access_check #(.KEY_W(KEY_W), .ERR_W(ERR_W)) uut (
    .acc_type_i(acc), .user_mode_i(um), .pg_user_i(pu), .pg_rw_i(prw),
    .pg_nx_i(pnx), .pkey_i(pkey), .wp_i(wp), .smep_i(smep), .nxe_i(nxe),
    .pae_i(pae), .pke_i(pke), .pks_i(pks), .lma_i(lma), .urights_i(ur),
    .srights_i(sr), .not_present_i(np), .rsvd_i(rsvd), .perm_o(perm),
    .allow_o(allow), .err_o(err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // behavioural reference
  int m_perm, m_allow, m_err;
  task automatic model();
    int r, w, x, rights, slot, key_r, key_w, pkf;
    bit viol;
    viol = um && !pu;
    r = viol ? 0 : 1;
    w = viol ? 0 : ((prw || (!um && !wp)) ? 1 : 0);
    x = (viol || pnx || (!um && smep && pu)) ? 0 : 1;
    rights = 0;
    if (lma == 1'b1) begin
      if (pu && pke) rights = int'(ur);
      if (!pu && pks) rights = int'(sr);
    end
    slot = (rights >>> (2 * int'(pkey))) & 3;
    key_r = (slot & 1) ? 0 : 1;
    key_w = key_r;
    if ((slot & 2) && (um || wp)) key_w = 0;
    r = r & key_r;
    w = w & key_w;
    m_perm = r + 2 * w + 4 * x;
    pkf = 0;
    if (!viol && acc == 2'd0 && !key_r) pkf = 1;
    if (!viol && acc == 2'd1 && !key_w) pkf = 1;
    m_allow = (acc != 2'd3) && ((m_perm >> acc) & 1) && !np && !rsvd;
    m_err = 0;
    if (!m_allow) begin
      if (!np) m_err += 1;
      if (acc == 2'd1) m_err += 2;
      if (um) m_err += 4;
      if (!np && rsvd) m_err += 8;
      if (acc == 2'd2 && ((nxe && pae) || smep)) m_err += 16;
      if (!np && !rsvd && pkf) m_err += 32;
    end
  endtask

  task automatic idle();
    acc = 0; um = 0; pu = 0; prw = 0; pnx = 0; wp = 0; smep = 0; nxe = 0;
    pae = 0; pke = 0; pks = 0; lma = 0; np = 0; rsvd = 0; pkey = 0; ur = 0; sr = 0;
  endtask

  // apply at posedge, compare with the model at the following negedge
  task automatic step();
    @(negedge clk);
    model();
    chk("R4/R2/R3 perm", int'(perm), m_perm);
    chk("R8 allow", int'(allow), m_allow);
    chk("R9 err", int'(err), m_err);
    @(posedge clk);
    #1;
  endtask

  initial begin
    idle();
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    #1;
    // idle: supervisor read, everything open
    @(negedge clk);
    chk("R4 idle perm", int'(perm), 7);
    chk("R8 idle allow", int'(allow), 1);
    chk("R8 idle err", int'(err), 0);
    @(posedge clk); #1;

    idle(); um = 1; pu = 0; step();
    chk("R1 user on sup page err", int'(err), 5);
    chk("R1 user on sup page perm", int'(perm), 0);

    idle(); acc = 1; wp = 0; step();
    chk("R2 sup write wp clear", int'(allow), 1);
    idle(); acc = 1; wp = 1; step();
    chk("R2 sup write wp set err", int'(err), 3);

    idle(); acc = 2; smep = 1; pu = 1; step();
    chk("R3 smep sup fetch err", int'(err), 'h11);
    idle(); acc = 2; um = 1; pu = 1; pnx = 1; nxe = 1; pae = 1; step();
    chk("R3 nx user fetch err", int'(err), 'h15);
    idle(); acc = 2; pnx = 1; pae = 1; step();
    chk("R10 no fetch bit without nxe", int'(err), 'h01);

    idle(); um = 1; pu = 1; pke = 1; ur = '1; pkey = 3; step();
    chk("R5 keys off outside long mode", int'(allow), 1);
    idle(); um = 1; pu = 1; lma = 1; ur = '1; pkey = 3; step();
    chk("R5 user enable clear", int'(allow), 1);
    idle(); um = 1; pu = 1; lma = 1; pke = 1; ur = '1; pkey = 3; step();
    chk("R7 user key ad err", int'(err), 'h25);
    idle(); lma = 1; pks = 1; pkey = 2; sr = RW'(1) << 4; step();
    chk("R5 sup register ad err", int'(err), 'h21);
    idle(); lma = 1; pks = 1; pkey = 15; sr = RW'(1) << 30; pu = 1; step();
    chk("R5 sup register ignored on user page", int'(allow), 1);

    idle(); acc = 1; um = 1; pu = 1; prw = 1; lma = 1; pke = 1; pkey = 5;
    ur = RW'(1) << 11; step();
    chk("R6 wd user write err", int'(err), 'h27);
    acc = 0; step();
    chk("R6 wd read kept", int'(perm), 'h5);
    idle(); acc = 1; prw = 1; lma = 1; pks = 1; pkey = 5; sr = RW'(1) << 11; step();
    chk("R6 wd ignored sup wp clear", int'(allow), 1);

    idle(); acc = 1; um = 1; np = 1; step();
    chk("R11 not present err", int'(err), 'h06);
    idle(); um = 1; pu = 1; rsvd = 1; lma = 1; pke = 1; ur = '1; step();
    chk("R11 rsvd over key err", int'(err), 'h0D);
    idle(); acc = 3; step();
    chk("R8 reserved type refused", int'(allow), 0);

    for (int i = 0; i < 3000; i++) begin
      {acc, um, pu, prw, pnx, wp, smep, nxe, pae, pke, pks, lma} = 13'($urandom);
      np   = ($urandom % 8) == 0;
      rsvd = ($urandom % 8) == 0;
      pkey = KEY_W'($urandom);
      ur   = RW'($urandom);
      sr   = RW'($urandom);
      step();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule